// File: doc/BRIEF.md
# Serial EEPROM access sequencer

This block runs one complete access to an I2C serial EEPROM: either a random read of a run of bytes or a write of bytes that stay inside one page. It does not drive the bus pins. It sits above a byte-level I2C master and gives that master one command at a time: a START, a byte to transmit, a byte to receive (with ACK or NACK), or a STOP. It then waits for the master's status before it sends the next command.

A client starts an access with a single-cycle request. The request carries a 16-bit memory address, a byte count and a direction. Write data is pulled from a byte stream, one byte per pop strobe. Read data leaves as a strobed byte stream. When the access ends, a one-cycle completion pulse carries the number of bytes moved, or all ones if there was an error.

The sequencer handles three recovery cases on its own:
- An EEPROM that is still busy with an internal write cycle does not acknowledge its address. The sequencer polls it again, up to a bounded number of attempts.
- When a bus master loses arbitration, the sequencer starts the access again from START.
- Every ending issues a STOP, except a failed START.

Top module: `eeseq_top`

## Requirements
- R1: After reset, `bus_cmd_valid`, `done` and `busy` are low, and they stay low until a request arrives.
- R2: Command codes on `bus_cmd_op` are 0 START, 1 transmit byte, 2 receive with ACK, 3 receive with NACK, 4 STOP. Status codes on `bus_rsp_code` are 0 ACK/OK, 1 NACK, 2 arbitration lost, 3 fault. Each command is a one-cycle `bus_cmd_valid` strobe. No further command is issued until a response has been accepted for it.
- R3: With 16-bit word addressing (ADDR16=1), a write runs START, then 0xA0, then address bits 15:8, then address bits 7:0, then the data bytes in stream order (one `wr_pop` per data byte), then STOP. The reported count equals the requested length.
- R4: With 8-bit word addressing (ADDR16=0), the device byte is 0xA0 with address bits 10:8 placed in bits 3:1. Only address bits 7:0 follow it as the word address.
- R5: A read runs the address phase, then a repeated START, then the device byte with bit 0 set, then one receive command per byte, then STOP. Every receive command uses ACK except the last, which uses NACK. Each received byte appears once on `rd_data` with `rd_valid`, in order.
- R6: A NACK to the write-intent device byte starts a new START with no STOP in between. After MAX_BUSY such NACKs in one access, the block issues STOP and reports an error.
- R7: Arbitration loss during START, the device bytes, the word-address bytes or the repeated START restarts the access from START. This does not count toward the busy limit.
- R8: If the first START returns NACK or fault, the access ends with an error and no STOP is issued.
- R9: A NACK on a data byte during a write ends the access with STOP and an error.
- R10: A NACK on a word-address byte, or on the read-intent device byte, ends the access with STOP and no error, with a count of 0.
- R11: A length of 0 issues STOP right after the address phase (write) or right after the read-intent device byte (read), with a count of 0.
- R12: `done` pulses for one cycle after the access ends. `done_count` holds the number of bytes ACKed or received, or all ones when `done_err` is set. `req_valid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start an access (taken only when idle) |
| req_write | input | 1 | 1 = page write, 0 = random read |
| req_addr | input | 16 | EEPROM memory address |
| req_len | input | LEN_W | Number of data bytes |
| busy | output | 1 | An access is in progress |
| wr_data | input | 8 | Next write byte of the input stream |
| wr_pop | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| done | output | 1 | Access finished (one cycle) |
| done_err | output | 1 | Access ended in error |
| done_count | output | LEN_W | Bytes moved, all ones on error |
| bus_cmd_valid | output | 1 | Command strobe to the byte master |
| bus_cmd_op | output | 3 | Command code |
| bus_cmd_byte | output | 8 | Byte to transmit |
| bus_rsp_valid | input | 1 | Status strobe from the byte master |
| bus_rsp_code | input | 2 | Status code |
| bus_rsp_byte | input | 8 | Received byte for receive commands |

## Verification
Some properties are checked by assertions on every cycle:
- Only one command is ever outstanding.
- A NACK receive command appears only for the last byte, and an ACK receive command only for earlier bytes.
- Pops and read strobes match the direction of the access.
- The busy-poll counter stays below its limit.
- `done` follows a STOP response in the next cycle.

The complete command order is shown only by the bench's scenarios, which compare it against a scripted bus model. The scenarios also cover:
- restart after NACK or arbitration loss, including proof that arbitration retries leave the poll budget untouched;
- STOP being withheld after a failed START;
- the 8-bit device-byte folding;
- the reported count.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;

  typedef enum logic [2:0] {
    OP_START     = 3'd0,
    OP_SEND      = 3'd1,
    OP_RECV_ACK  = 3'd2,
    OP_RECV_NACK = 3'd3,
    OP_STOP      = 3'd4
  } bus_op_e;

  typedef enum logic [1:0] {
    RS_ACK   = 2'd0,
    RS_NACK  = 2'd1,
    RS_ARB   = 2'd2,
    RS_FAULT = 2'd3
  } bus_rsp_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_DEVW,
    ST_WHI,
    ST_WLO,
    ST_WDATA,
    ST_RSTART,
    ST_DEVR,
    ST_RDATA,
    ST_STOP,
    ST_DONE
  } seq_st_e;

endpackage

// File: rtl/eeseq_addr_fmt.sv
module eeseq_addr_fmt #(
  parameter bit         ADDR16   = 1'b1,
  parameter logic [7:0] DEV_ADDR = 8'hA0
) (
  input  logic [15:0] addr_i,
  output logic [7:0]  dev_w_o,
  output logic [7:0]  dev_r_o,
  output logic [7:0]  word_hi_o,
  output logic [7:0]  word_lo_o
);

  logic [7:0] dev_base;

  generate
    if (ADDR16) begin : g_wide
      assign dev_base  = {DEV_ADDR[7:1], 1'b0};
      assign word_hi_o = addr_i[15:8];
    end else begin : g_narrow
      // Upper address bits ride inside the device byte.
      assign dev_base  = {DEV_ADDR[7:4], DEV_ADDR[3:1] | addr_i[10:8], 1'b0};
      assign word_hi_o = 8'h00;
      logic unused_hi;
      assign unused_hi = ^addr_i[15:11];
    end
  endgenerate

  assign word_lo_o = addr_i[7:0];
  assign dev_w_o   = dev_base;
  assign dev_r_o   = {dev_base[7:1], 1'b1};

endmodule

// File: rtl/eeseq_busy_ctr.sv
module eeseq_busy_ctr #(
  parameter int MAX_BUSY = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic exhausted_o
);

  localparam int CW = $clog2(MAX_BUSY + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // The NACK that arrives with MAX_BUSY-1 already counted is the last one allowed.
  assign exhausted_o = (cnt_q == CW'(MAX_BUSY - 1));

  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(MAX_BUSY));

endmodule

// File: rtl/eeseq_ctrl.sv
module eeseq_ctrl
  import eeseq_pkg::*;
#(
  parameter bit ADDR16 = 1'b1,
  parameter int LEN_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic [15:0]      addr_o,
  input  logic [7:0]       dev_w_i,
  input  logic [7:0]       dev_r_i,
  input  logic [7:0]       word_hi_i,
  input  logic [7:0]       word_lo_i,
  output logic             poll_clr_o,
  output logic             poll_inc_o,
  input  logic             poll_exh_i,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             done_err,
  output logic [LEN_W-1:0] done_count,
  output logic             bus_cmd_valid,
  output logic [2:0]       bus_cmd_op,
  output logic [7:0]       bus_cmd_byte,
  input  logic             bus_rsp_valid,
  input  logic [1:0]       bus_rsp_code,
  input  logic [7:0]       bus_rsp_byte
);

  seq_st_e          st_q, st_d;
  logic             pend_q, pend_d;
  logic             err_q, err_d;
  logic             wr_q, wr_d;
  logic [LEN_W-1:0] xfer_q, xfer_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [15:0]      addr_q, addr_d;

  bus_op_e  op;
  bus_rsp_e rc;
  logic     on_bus, issue, take, last_byte, got_byte;

  assign rc        = bus_rsp_e'(bus_rsp_code);
  assign on_bus    = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign issue     = on_bus && !pend_q;
  assign take      = pend_q && bus_rsp_valid;
  assign last_byte = ({1'b0, xfer_q} + 1'b1) == {1'b0, len_q};
  assign got_byte  = (rc == RS_ACK) || (rc == RS_NACK);

  // Command presented to the byte master
  always_comb begin
    op           = OP_SEND;
    bus_cmd_byte = 8'h00;
    case (st_q)
      ST_START, ST_RSTART: op = OP_START;
      ST_DEVW:  bus_cmd_byte = dev_w_i;
      ST_WHI:   bus_cmd_byte = word_hi_i;
      ST_WLO:   bus_cmd_byte = word_lo_i;
      ST_WDATA: bus_cmd_byte = wr_data;
      ST_DEVR:  bus_cmd_byte = dev_r_i;
      ST_RDATA: op = last_byte ? OP_RECV_NACK : OP_RECV_ACK;
      ST_STOP:  op = OP_STOP;
      default:  op = OP_SEND;
    endcase
  end

  assign bus_cmd_valid = issue;
  assign bus_cmd_op    = op;
  assign wr_pop        = issue && (st_q == ST_WDATA);
  assign rd_valid      = take && (st_q == ST_RDATA) && got_byte;
  assign rd_data       = bus_rsp_byte;

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    pend_d     = pend_q;
    err_d      = err_q;
    wr_d       = wr_q;
    xfer_d     = xfer_q;
    len_d      = len_q;
    addr_d     = addr_q;
    poll_clr_o = 1'b0;
    poll_inc_o = 1'b0;
    if (issue) pend_d = 1'b1;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          st_d       = ST_START;
          wr_d       = req_write;
          len_d      = req_len;
          addr_d     = req_addr;
          xfer_d     = '0;
          err_d      = 1'b0;
          poll_clr_o = 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: begin
        if (take) begin
          pend_d = 1'b0;
          case (st_q)
            ST_START: begin
              if (rc == RS_ACK)      st_d = ST_DEVW;
              else if (rc == RS_ARB) st_d = ST_START;
              else begin
                err_d = 1'b1;       // STOP withheld: START never took the bus
                st_d  = ST_DONE;
              end
            end
            ST_DEVW: begin
              case (rc)
                RS_ACK:  st_d = ADDR16 ? ST_WHI : ST_WLO;
                RS_ARB:  st_d = ST_START;
                RS_NACK: begin
                  if (poll_exh_i) begin
                    err_d = 1'b1;
                    st_d  = ST_STOP;
                  end else begin
                    poll_inc_o = 1'b1;
                    st_d       = ST_START;
                  end
                end
                default: begin err_d = 1'b1; st_d = ST_STOP; end
              endcase
            end
            ST_WHI, ST_WLO: begin
              case (rc)
                RS_ACK: begin
                  if (st_q == ST_WHI) st_d = ST_WLO;
                  else if (!wr_q)     st_d = ST_RSTART;
                  else                st_d = (len_q == '0) ? ST_STOP : ST_WDATA;
                end
                RS_ARB:  st_d = ST_START;
                RS_NACK: st_d = ST_STOP;
                default: begin err_d = 1'b1; st_d = ST_STOP; end
              endcase
            end
            ST_WDATA: begin
              if (rc == RS_ACK) begin
                xfer_d = xfer_q + 1'b1;
                st_d   = last_byte ? ST_STOP : ST_WDATA;
              end else begin
                err_d = 1'b1;
                st_d  = ST_STOP;
              end
            end
            ST_RSTART: begin
              if (rc == RS_ACK)      st_d = ST_DEVR;
              else if (rc == RS_ARB) st_d = ST_START;
              else begin err_d = 1'b1; st_d = ST_STOP; end
            end
            ST_DEVR: begin
              case (rc)
                RS_ACK:  st_d = (len_q == '0) ? ST_STOP : ST_RDATA;
                RS_ARB:  st_d = ST_START;
                RS_NACK: st_d = ST_STOP;
                default: begin err_d = 1'b1; st_d = ST_STOP; end
              endcase
            end
            ST_RDATA: begin
              if (got_byte) begin
                xfer_d = xfer_q + 1'b1;
                st_d   = (last_byte || rc == RS_NACK) ? ST_STOP : ST_RDATA;
              end else begin
                err_d = 1'b1;
                st_d  = ST_STOP;
              end
            end
            ST_STOP: st_d = ST_DONE;
            default: st_d = ST_IDLE;
          endcase
        end
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      wr_q   <= 1'b0;
      xfer_q <= '0;
      len_q  <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      err_q  <= err_d;
      wr_q   <= wr_d;
      xfer_q <= xfer_d;
      len_q  <= len_d;
      addr_q <= addr_d;
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign addr_o     = addr_q;
  assign done       = (st_q == ST_DONE);
  assign done_err   = err_q;
  assign done_count = err_q ? '1 : xfer_q;

  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |=> !bus_cmd_valid);

  assert_nack_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd_op == 3'd3) |-> ({1'b0, xfer_q} + 1'b1 == {1'b0, len_q}));

  assert_ack_not_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd_valid && bus_cmd_op == 3'd2) |-> ({1'b0, xfer_q} + 1'b1 < {1'b0, len_q}));

  assert_rd_only_reading_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !wr_q);

  assert_pop_only_writing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pop |-> wr_q);

  assert_stop_then_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && st_q == ST_STOP) |=> done);

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_err) |-> (done_count <= len_q));

endmodule

// File: rtl/eeseq_top.sv
module eeseq_top #(
  parameter bit         ADDR16   = 1'b1,
  parameter logic [7:0] DEV_ADDR = 8'hA0,
  parameter int         MAX_BUSY = 200,
  parameter int         LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  input  logic [7:0]       wr_data,
  output logic             wr_pop,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             done_err,
  output logic [LEN_W-1:0] done_count,
  output logic             bus_cmd_valid,
  output logic [2:0]       bus_cmd_op,
  output logic [7:0]       bus_cmd_byte,
  input  logic             bus_rsp_valid,
  input  logic [1:0]       bus_rsp_code,
  input  logic [7:0]       bus_rsp_byte
);

  logic [15:0] addr_q;
  logic [7:0]  dev_w, dev_r, word_hi, word_lo;
  logic        poll_clr, poll_inc, poll_exh;

  eeseq_addr_fmt #(.ADDR16(ADDR16), .DEV_ADDR(DEV_ADDR)) u_fmt (
    .addr_i    (addr_q),
    .dev_w_o   (dev_w),
    .dev_r_o   (dev_r),
    .word_hi_o (word_hi),
    .word_lo_o (word_lo)
  );

  eeseq_busy_ctr #(.MAX_BUSY(MAX_BUSY)) u_poll (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (poll_clr),
    .inc_i       (poll_inc),
    .exhausted_o (poll_exh)
  );

  eeseq_ctrl #(.ADDR16(ADDR16), .LEN_W(LEN_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .busy          (busy),
    .addr_o        (addr_q),
    .dev_w_i       (dev_w),
    .dev_r_i       (dev_r),
    .word_hi_i     (word_hi),
    .word_lo_i     (word_lo),
    .poll_clr_o    (poll_clr),
    .poll_inc_o    (poll_inc),
    .poll_exh_i    (poll_exh),
    .wr_data       (wr_data),
    .wr_pop        (wr_pop),
    .rd_data       (rd_data),
    .rd_valid      (rd_valid),
    .done          (done),
    .done_err      (done_err),
    .done_count    (done_count),
    .bus_cmd_valid (bus_cmd_valid),
    .bus_cmd_op    (bus_cmd_op),
    .bus_cmd_byte  (bus_cmd_byte),
    .bus_rsp_valid (bus_rsp_valid),
    .bus_rsp_code  (bus_rsp_code),
    .bus_rsp_byte  (bus_rsp_byte)
  );

endmodule

// File: tb/eeseq_bus_model.sv
module eeseq_bus_model (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic [7:0] cmd_byte,
  output logic       rsp_valid,
  output logic [1:0] rsp_code,
  output logic [7:0] rsp_byte
);
  int arb_idx   = -1;
  int nack_idx  = -1;
  int fault_idx = -1;
  int busy_cfg  = 0;
  int n, busy_left, rd_i, dly;
  logic [2:0] log_op   [0:63];
  logic [7:0] log_byte [0:63];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_code <= 2'd0; rsp_byte <= 8'd0;
      n <= 0; busy_left <= 0; rd_i <= 0; dly <= 0;
    end else begin
      rsp_valid <= 1'b0;
      if (clr) begin
        n <= 0; busy_left <= busy_cfg; rd_i <= 0; dly <= 0;
      end else if (cmd_valid) begin
        if (n < 64) begin log_op[n] <= cmd_op; log_byte[n] <= cmd_byte; end
        n   <= n + 1;
        dly <= 2;
        if (n == arb_idx)        rsp_code <= 2'd2;
        else if (n == nack_idx)  rsp_code <= 2'd1;
        else if (n == fault_idx) rsp_code <= 2'd3;
        else if (cmd_op == 3'd1 && cmd_byte[0] == 1'b0 && cmd_byte[7:4] == 4'hA && busy_left > 0) begin
          rsp_code  <= 2'd1;
          busy_left <= busy_left - 1;
        end else rsp_code <= 2'd0;
        if (cmd_op == 3'd2 || cmd_op == 3'd3) begin
          rsp_byte <= 8'h30 + 8'(rd_i);
          rd_i     <= rd_i + 1;
        end
      end else if (dly > 0) begin
        dly <= dly - 1;
        if (dly == 1) rsp_valid <= 1'b1;
      end
    end
  end
endmodule

// File: tb/eeseq_top_bench.sv
`timescale 1ns/1ps
module eeseq_top_bench;
  localparam logic [2:0] S = 3'd0, W = 3'd1, RA = 3'd2, RN = 3'd3, P = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic req_valid_a = 1'b0, req_valid_b = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_len = 8'h0;

  logic busy_a, wr_pop_a, rd_valid_a, done_a, err_a, cv_a, rv_a;
  logic busy_b, wr_pop_b, rd_valid_b, done_b, err_b, cv_b, rv_b;
  logic [7:0] rd_data_a, cnt_a, cb_a, rb_a, rd_data_b, cnt_b, cb_b, rb_b;
  logic [2:0] op_a, op_b;
  logic [1:0] rc_a, rc_b;
  logic [7:0] pop_a, pop_b, wd_a, wd_b;

  int total = 0, fails = 0, r2_viol = 0;
  logic [2:0] eop [0:63];
  logic [7:0] eby [0:63];
  int en;
  logic [7:0] got_rd [0:63];

  always #2 clk = ~clk;

  assign wd_a = 8'hD0 + pop_a;
  assign wd_b = 8'hD0 + pop_b;
  always @(posedge clk) begin
    if (clr) begin pop_a <= 8'd0; pop_b <= 8'd0; end
    else begin
      if (wr_pop_a) pop_a <= pop_a + 8'd1;
      if (wr_pop_b) pop_b <= pop_b + 8'd1;
    end
  end

  eeseq_top #(.ADDR16(1'b1), .MAX_BUSY(4)) u_eeseq_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid_a), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy_a), .wr_data(wd_a), .wr_pop(wr_pop_a),
    .rd_data(rd_data_a), .rd_valid(rd_valid_a), .done(done_a), .done_err(err_a),
    .done_count(cnt_a), .bus_cmd_valid(cv_a), .bus_cmd_op(op_a), .bus_cmd_byte(cb_a),
    .bus_rsp_valid(rv_a), .bus_rsp_code(rc_a), .bus_rsp_byte(rb_a));

  eeseq_top #(.ADDR16(1'b0), .MAX_BUSY(4)) u_eeseq_top_b8 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid_b), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy_b), .wr_data(wd_b), .wr_pop(wr_pop_b),
    .rd_data(rd_data_b), .rd_valid(rd_valid_b), .done(done_b), .done_err(err_b),
    .done_count(cnt_b), .bus_cmd_valid(cv_b), .bus_cmd_op(op_b), .bus_cmd_byte(cb_b),
    .bus_rsp_valid(rv_b), .bus_rsp_code(rc_b), .bus_rsp_byte(rb_b));

  eeseq_bus_model m_a (.clk(clk), .rst_n(rst_n), .clr(clr), .cmd_valid(cv_a), .cmd_op(op_a),
    .cmd_byte(cb_a), .rsp_valid(rv_a), .rsp_code(rc_a), .rsp_byte(rb_a));
  eeseq_bus_model m_b (.clk(clk), .rst_n(rst_n), .clr(clr), .cmd_valid(cv_b), .cmd_op(op_b),
    .cmd_byte(cb_b), .rsp_valid(rv_b), .rsp_code(rc_b), .rsp_byte(rb_b));

  // R2 monitor: a command while the model still owes a response is a violation
  always @(negedge clk) begin
    if (rst_n && ((cv_a && (m_a.dly > 0 || rv_a)) || (cv_b && (m_b.dly > 0 || rv_b))))
      r2_viol++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic e(input logic [2:0] op, input logic [7:0] b);
    eop[en] = op; eby[en] = b; en++;
  endtask

  function automatic logic [7:0] devb(input int sel, input logic [15:0] a);
    return (sel == 0) ? 8'hA0 : (8'hA0 | {4'h0, a[10:8], 1'b0});
  endfunction

  task automatic e_addr(input int sel, input logic [15:0] a);
    e(S, 8'h00); e(W, devb(sel, a));
    if (sel == 0) e(W, a[15:8]);
    e(W, a[7:0]);
  endtask

  task automatic e_write(input int sel, input logic [15:0] a, input int len);
    e_addr(sel, a);
    for (int i = 0; i < len; i++) e(W, 8'hD0 + 8'(i));
    e(P, 8'h00);
  endtask

  task automatic e_read(input int sel, input logic [15:0] a, input int len);
    e_addr(sel, a);
    e(S, 8'h00); e(W, devb(sel, a) | 8'h01);
    for (int i = 0; i < len; i++) e((i == len - 1) ? RN : RA, 8'h00);
    e(P, 8'h00);
  endtask

  task automatic run(input int sel, input bit wr, input logic [15:0] addr, input logic [7:0] len,
                     input int busy, input int arb, input int nk, input int flt, input bit poke,
                     input logic [7:0] xcnt, input bit xerr, input int xrd, input string tag);
    int cyc, nrd, nlog, nlog2;
    logic [7:0] gcnt;
    bit gerr, gdone;
    @(negedge clk);
    m_a.arb_idx = arb; m_a.nack_idx = nk; m_a.fault_idx = flt; m_a.busy_cfg = busy;
    m_b.arb_idx = arb; m_b.nack_idx = nk; m_b.fault_idx = flt; m_b.busy_cfg = busy;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    req_write = wr; req_addr = addr; req_len = len;
    if (sel == 0) req_valid_a = 1'b1; else req_valid_b = 1'b1;
    @(negedge clk);
    req_valid_a = 1'b0; req_valid_b = 1'b0;
    nrd = 0; gdone = 1'b0; cyc = 0; gcnt = 8'h0; gerr = 1'b0;
    while (!gdone && cyc < 3000) begin
      if (poke && cyc == 4) begin
        req_write = ~wr; req_addr = 16'h7777; req_len = 8'd9;
        if (sel == 0) req_valid_a = 1'b1; else req_valid_b = 1'b1;
      end else begin
        req_valid_a = 1'b0; req_valid_b = 1'b0;
      end
      if ((sel == 0) ? rd_valid_a : rd_valid_b) begin
        if (nrd < 64) got_rd[nrd] = (sel == 0) ? rd_data_a : rd_data_b;
        nrd++;
      end
      if ((sel == 0) ? done_a : done_b) begin
        gdone = 1'b1;
        gcnt  = (sel == 0) ? cnt_a : cnt_b;
        gerr  = (sel == 0) ? err_a : err_b;
      end
      @(negedge clk);
      cyc++;
    end
    req_valid_a = 1'b0; req_valid_b = 1'b0;
    chk(gdone, {tag, " R12 done seen"}, gdone, 1);
    // done is a single pulse
    chk(((sel == 0) ? done_a : done_b) == 1'b0, {tag, " R12 done one cycle"}, 1, 0);
    nlog = (sel == 0) ? m_a.n : m_b.n;
    chk(nlog == en, {tag, " command count"}, nlog, en);
    for (int i = 0; i < en && i < nlog && i < 64; i++) begin
      logic [2:0] aop;
      logic [7:0] aby;
      aop = (sel == 0) ? m_a.log_op[i] : m_b.log_op[i];
      aby = (sel == 0) ? m_a.log_byte[i] : m_b.log_byte[i];
      chk(aop == eop[i], $sformatf("%s op[%0d]", tag, i), aop, eop[i]);
      if (eop[i] == W) chk(aby == eby[i], $sformatf("%s byte[%0d]", tag, i), aby, eby[i]);
    end
    chk(gerr == xerr, {tag, " R12 done_err"}, gerr, xerr);
    chk(gcnt == xcnt, {tag, " R12 done_count"}, gcnt, xcnt);
    chk(nrd == xrd, {tag, " R5 rd_valid count"}, nrd, xrd);
    for (int i = 0; i < nrd && i < xrd && i < 64; i++)
      chk(got_rd[i] == 8'h30 + 8'(i), $sformatf("%s R5 rd_data[%0d]", tag, i), got_rd[i], 8'h30 + i);
    repeat (8) @(negedge clk);
    nlog2 = (sel == 0) ? m_a.n : m_b.n;
    chk(nlog2 == nlog, {tag, " R12 quiet after done"}, nlog2, nlog);
    chk(((sel == 0) ? busy_a : busy_b) == 1'b0, {tag, " R12 idle after done"}, 1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: quiet after reset
    chk(!cv_a && !cv_b, "R1 no command", cv_a | cv_b, 0);
    chk(!done_a && !done_b, "R1 done low", done_a | done_b, 0);
    chk(!busy_a && !busy_b, "R1 busy low", busy_a | busy_b, 0);

    // R3 write, with an ignored request while busy (R12)
    en = 0; e_write(0, 16'h1234, 3);
    run(0, 1, 16'h1234, 3, 0, -1, -1, -1, 1, 8'd3, 0, 0, "R3 write");

    // R3 / R11 write length sweep
    for (int l = 0; l < 6; l++) begin
      en = 0; e_write(0, 16'h1200 + 16'(l * 7), l);
      run(0, 1, 16'h1200 + 16'(l * 7), 8'(l), 0, -1, -1, -1, 0, 8'(l), 0, 0,
          (l == 0) ? "R11 write len0" : "R3 write sweep");
    end

    // R5 / R11 read length sweep
    for (int l = 0; l < 7; l++) begin
      en = 0; e_read(0, 16'h0340 + 16'(l), l);
      run(0, 0, 16'h0340 + 16'(l), 8'(l), 0, -1, -1, -1, 0, 8'(l), 0, l,
          (l == 0) ? "R11 read len0" : "R5 read sweep");
    end

    // R6 busy polling then success
    en = 0; e(S, 0); e(W, 8'hA0); e(S, 0); e(W, 8'hA0); e_write(0, 16'h1234, 1);
    run(0, 1, 16'h1234, 1, 2, -1, -1, -1, 0, 8'd1, 0, 0, "R6 busy retry");

    // R6 busy exhaustion after MAX_BUSY=4 attempts
    en = 0;
    for (int k = 0; k < 4; k++) begin e(S, 0); e(W, 8'hA0); end
    e(P, 0);
    run(0, 1, 16'h1234, 2, 10, -1, -1, -1, 0, 8'hFF, 1, 0, "R6 busy limit");

    // R7 arbitration loss on device byte does not use the poll budget
    en = 0; e(S, 0); e(W, 8'hA0);
    for (int k = 0; k < 3; k++) begin e(S, 0); e(W, 8'hA0); end
    e_write(0, 16'h1234, 1);
    run(0, 1, 16'h1234, 1, 3, 1, -1, -1, 0, 8'd1, 0, 0, "R7 arb devw");

    // R7 arbitration loss on first START and on repeated START
    en = 0; e(S, 0); e_read(0, 16'h0456, 2);
    run(0, 0, 16'h0456, 2, 0, 0, -1, -1, 0, 8'd2, 0, 2, "R7 arb start");
    en = 0; e(S, 0); e(W, 8'hA0); e(W, 8'h04); e(W, 8'h56); e(S, 0); e_read(0, 16'h0456, 1);
    run(0, 0, 16'h0456, 1, 0, 4, -1, -1, 0, 8'd1, 0, 1, "R7 arb rstart");

    // R8 START fault and START NACK: no STOP
    en = 0; e(S, 0);
    run(0, 1, 16'h1234, 2, 0, -1, -1, 0, 0, 8'hFF, 1, 0, "R8 start fault");
    en = 0; e(S, 0);
    run(0, 0, 16'h1234, 2, 0, -1, 0, -1, 0, 8'hFF, 1, 0, "R8 start nack");

    // R9 data NACK during write
    en = 0; e(S, 0); e(W, 8'hA0); e(W, 8'h12); e(W, 8'h34); e(W, 8'hD0); e(W, 8'hD1); e(P, 0);
    run(0, 1, 16'h1234, 3, 0, -1, 5, -1, 0, 8'hFF, 1, 0, "R9 data nack");

    // R10 NACK on word address bytes and on read-intent device byte
    en = 0; e(S, 0); e(W, 8'hA0); e(W, 8'h04); e(W, 8'h56); e(P, 0);
    run(0, 0, 16'h0456, 3, 0, -1, 3, -1, 0, 8'd0, 0, 0, "R10 addr lo nack");
    en = 0; e(S, 0); e(W, 8'hA0); e(W, 8'h12); e(P, 0);
    run(0, 1, 16'h1234, 3, 0, -1, 2, -1, 0, 8'd0, 0, 0, "R10 addr hi nack");
    en = 0; e(S, 0); e(W, 8'hA0); e(W, 8'h04); e(W, 8'h56); e(S, 0); e(W, 8'hA1); e(P, 0);
    run(0, 0, 16'h0456, 3, 0, -1, 5, -1, 0, 8'd0, 0, 0, "R10 devr nack");

    // R4 8-bit word addressing
    en = 0; e_write(1, 16'h0523, 2);
    run(1, 1, 16'h0523, 2, 0, -1, -1, -1, 0, 8'd2, 0, 0, "R4 write8");
    for (int k = 0; k < 8; k++) begin
      en = 0; e_read(1, {5'b0, 3'(k), 8'h5F}, 2);
      run(1, 0, {5'b0, 3'(k), 8'h5F}, 2, 0, -1, -1, -1, 0, 8'd2, 0, 2, "R4 read8 sweep");
    end

    chk(r2_viol == 0, "R2 single outstanding command", r2_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule